// File: doc/BRIEF.md
# Fast Ethernet receive line decoder

This block turns a recovered three-level line symbol stream into a nibble-wide receive data stream with data-valid and error flags. One symbol arrives per bit-clock cycle, already sliced and timed by upstream analog circuitry. The block first recovers the scrambled binary stream from level transitions. It then descrambles that stream with an 11-bit keystream generator that it trains on the idle pattern. Finally it locates code-group boundaries from the start-of-stream delimiter and maps each 5-bit group to a 4-bit nibble.

The whole block runs on the recovered bit clock. A one-cycle strobe marks each nibble boundary, and the data, valid and error outputs change only in strobe cycles. That gives a downstream MAC a nibble-rate interface without a second clock domain. Lock to the keystream is gained on idle and lost after a long run with no idle, so the block recovers by itself after a line disturbance.

Top module: `fe_rx_decoder`

## Requirements
- R1: Symbols are coded on `sym_i` as 2'b00 = 0, 2'b01 = +1, 2'b11 = -1. A recovered scrambled bit is 1 when the symbol differs from the one in the previous cycle, and 0 when it is the same.
- R2: Lock (`lock_o`) is declared only after LOCK_RUN (30) consecutive received bits agree with a keystream prediction that assumes an all-ones plain stream. It is 0 during and after reset until then.
- R3: Once locked, the keystream follows k[n] = k[n-11] XOR k[n-9]. The descrambled bit is the received bit XOR k[n].
- R4: Outside a frame and while locked, the bit sequence 11000 followed by 10001 (start delimiter, leftmost bit received first) fixes group alignment. `rx_dv_o` first rises on the strobe of the first group after it.
- R5: Data groups map to nibbles as follows: 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F.
- R6: In a frame, the end groups 01101 or 00111, or the idle group 11111, end the frame. `rx_dv_o` goes to 0 on that group's strobe.
- R7: Any other group inside a frame gives `rx_dv_o`=1, `rx_er_o`=1 and `rxd_o`=4'hE. The frame continues after it. `rx_er_o` is never 1 without `rx_dv_o`.
- R8: While locked, if UNLOCK_LIM bits pass without a run of IDLE_RUN (12) consecutive descrambled ones, lock drops. Any open frame closes at the next strobe.
- R9: `rx_stb_o` pulses for one cycle every five cycles, with its phase reset by the start delimiter. `rxd_o`, `rx_dv_o` and `rx_er_o` change only in strobe cycles.
- R10: A first delimiter half (11000) that is not followed by the second half (10001) opens no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_i | input | 2 | Line symbol level for this bit period |
| rxd_o | output | 4 | Received nibble |
| rx_dv_o | output | 1 | Nibble belongs to a frame |
| rx_er_o | output | 1 | Invalid code group in frame |
| rx_stb_o | output | 1 | Nibble boundary strobe |
| lock_o | output | 1 | Descrambler locked to the keystream |

## Verification
The bench scrambles and line-encodes its own frames with several keystream seeds and data patterns, covering all sixteen data groups. It compares the collected nibbles in order, so a wrong tap, a mirrored group bit order or an off-by-one alignment after the delimiter garbles or shifts the nibbles. Lock timing is probed just short of the required idle run and well past it; a block that locks too early, or only on a single matching bit, shows up there. Further cases target frame endings. A bad code mid-frame must flag an error without closing the frame. An idle-terminated frame and a lone first delimiter half must leave valid low. A held line level, which looks like silence to the idle detector, must drop lock after the configured count and not earlier.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;
  localparam logic [2*GRP_W-1:0] SSD_PAT = 10'b1100010001;

  typedef enum logic [1:0] {GC_DATA, GC_END, GC_IDLE, GC_BAD} grp_cls_e;

  typedef struct packed {
    grp_cls_e         cls;
    logic [NIB_W-1:0] nib;
  } grp_dec_t;

  function automatic grp_dec_t decode_grp(input logic [GRP_W-1:0] g);
    grp_dec_t r;
    r.cls = GC_DATA;
    r.nib = '0;
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      5'b01101, 5'b00111: r.cls = GC_END;
      5'b11111: r.cls = GC_IDLE;
      default: begin
        r.cls = GC_BAD;
        r.nib = 4'hE;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fe_rx_line.sv
module fe_rx_line (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sym_i,
  output logic       nrz_o
);
  logic [1:0] prev_q;
  logic       nrzi_q;
  logic       nrzi_d1;

  // previous level tracks the line even in reset, so the first comparison is real
  always_ff @(posedge clk) prev_q <= sym_i;

  // three-level to two-level: toggle on any level change
  always_ff @(posedge clk) begin
    if (rst) begin
      nrzi_q  <= 1'b0;
      nrzi_d1 <= 1'b0;
      nrz_o   <= 1'b0;
    end else begin
      nrzi_q  <= nrzi_q ^ (sym_i != prev_q);
      nrzi_d1 <= nrzi_q;
      nrz_o   <= nrzi_q ^ nrzi_d1;
    end
  end

  assert_chg_one_R1: assert property (@(posedge clk) disable iff (rst)
    (sym_i != $past(sym_i)) |=> ##1 nrz_o);
  assert_hold_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (sym_i == $past(sym_i)) |=> ##1 !nrz_o);
endmodule

// File: rtl/fe_rx_descr.sv
module fe_rx_descr #(
  parameter int LFSR_W     = 11,
  parameter int LFSR_TAP   = 9,
  parameter int LOCK_RUN   = 30,
  parameter int IDLE_RUN   = 12,
  parameter int UNLOCK_LIM = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic scr_i,
  output logic bit_o,
  output logic vld_o,
  output logic lock_o
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int ONE_W = $clog2(IDLE_RUN + 1);
  localparam int SIL_W = $clog2(UNLOCK_LIM + 1);

  logic [LFSR_W-1:0] lfsr_q;
  logic [RUN_W-1:0]  run_q;
  logic [ONE_W-1:0]  ones_q;
  logic [SIL_W-1:0]  sil_q;
  logic              locked_q;
  logic              pred;
  logic              obs;
  logic              plain;
  logic              idle_seen;

  assign pred      = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP-1];
  assign obs       = ~scr_i;
  assign plain     = scr_i ^ pred;
  assign idle_seen = plain && (ones_q == ONE_W'(IDLE_RUN - 1));
  assign lock_o    = locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q   <= '0;
      run_q    <= '0;
      ones_q   <= '0;
      sil_q    <= '0;
      locked_q <= 1'b0;
      bit_o    <= 1'b0;
      vld_o    <= 1'b0;
    end else if (!locked_q) begin
      // training: assume idle, so keystream bit is the inverse of the line bit
      lfsr_q <= {lfsr_q[LFSR_W-2:0], obs};
      ones_q <= '0;
      sil_q  <= '0;
      bit_o  <= 1'b0;
      vld_o  <= 1'b0;
      if (pred == obs) begin
        if (run_q == RUN_W'(LOCK_RUN - 1)) begin
          locked_q <= 1'b1;
          run_q    <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], pred};
      bit_o  <= plain;
      vld_o  <= 1'b1;
      if (!plain) ones_q <= '0;
      else if (ones_q != ONE_W'(IDLE_RUN - 1)) ones_q <= ones_q + 1'b1;
      if (idle_seen) begin
        sil_q <= '0;
      end else if (sil_q == SIL_W'(UNLOCK_LIM - 1)) begin
        locked_q <= 1'b0;
        sil_q    <= '0;
        vld_o    <= 1'b0;
      end else begin
        sil_q <= sil_q + 1'b1;
      end
    end
  end

  assert_lock_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> ($past(run_q) == RUN_W'(LOCK_RUN - 1)));
  assert_unlock_silence_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_q) |-> ($past(sil_q) == SIL_W'(UNLOCK_LIM - 1)));
  assert_valid_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> $past(locked_q));
endmodule

// File: rtl/fe_rx_align.sv
module fe_rx_align
  import fe_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  input  logic             vld_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             dv_o,
  output logic             er_o,
  output logic             stb_o
);
  localparam int SH_W = 2 * GRP_W - 1;
  localparam int PH_W = $clog2(GRP_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

  logic [SH_W-1:0]    sh_q;
  logic [2*GRP_W-1:0] sh_n;
  logic [PH_W-1:0]    ph_q;
  logic               in_q;
  grp_dec_t           dec;

  assign sh_n = {sh_q, bit_i};
  assign dec  = decode_grp(sh_n[GRP_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      ph_q  <= '0;
      in_q  <= 1'b0;
      rxd_o <= '0;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
      stb_o <= 1'b0;
    end else begin
      sh_q  <= sh_n[SH_W-1:0];
      stb_o <= (ph_q == PH_LAST);
      if (!in_q && vld_i && sh_n == SSD_PAT) begin
        in_q <= 1'b1;
        ph_q <= '0;
      end else begin
        ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        if (!vld_i) in_q <= 1'b0;
        if (ph_q == PH_LAST) begin
          if (in_q && vld_i) begin
            case (dec.cls)
              GC_DATA: begin
                rxd_o <= dec.nib;
                dv_o  <= 1'b1;
                er_o  <= 1'b0;
              end
              GC_BAD: begin
                rxd_o <= dec.nib;
                dv_o  <= 1'b1;
                er_o  <= 1'b1;
              end
              default: begin
                rxd_o <= '0;
                dv_o  <= 1'b0;
                er_o  <= 1'b0;
                in_q  <= 1'b0;
              end
            endcase
          end else begin
            rxd_o <= '0;
            dv_o  <= 1'b0;
            er_o  <= 1'b0;
          end
        end
      end
    end
  end

  assert_stb_single_R9: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);
  assert_dv_on_stb_R9: assert property (@(posedge clk) disable iff (rst)
    (dv_o != $past(dv_o)) |-> stb_o);
  assert_er_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    er_o |-> dv_o);
  assert_bad_nibble_R7: assert property (@(posedge clk) disable iff (rst)
    er_o |-> (rxd_o == 4'hE));
endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
  parameter int LFSR_W     = 11,
  parameter int LFSR_TAP   = 9,
  parameter int LOCK_RUN   = 30,
  parameter int IDLE_RUN   = 12,
  parameter int UNLOCK_LIM = 16384
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sym_i,
  output logic [3:0] rxd_o,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic       rx_stb_o,
  output logic       lock_o
);
  logic nrz;
  logic plain_bit;
  logic plain_vld;

  fe_rx_line u_line (
    .clk   (clk),
    .rst   (rst),
    .sym_i (sym_i),
    .nrz_o (nrz)
  );

  fe_rx_descr #(
    .LFSR_W     (LFSR_W),
    .LFSR_TAP   (LFSR_TAP),
    .LOCK_RUN   (LOCK_RUN),
    .IDLE_RUN   (IDLE_RUN),
    .UNLOCK_LIM (UNLOCK_LIM)
  ) u_descr (
    .clk    (clk),
    .rst    (rst),
    .scr_i  (nrz),
    .bit_o  (plain_bit),
    .vld_o  (plain_vld),
    .lock_o (lock_o)
  );

  fe_rx_align u_align (
    .clk   (clk),
    .rst   (rst),
    .bit_i (plain_bit),
    .vld_i (plain_vld),
    .rxd_o (rxd_o),
    .dv_o  (rx_dv_o),
    .er_o  (rx_er_o),
    .stb_o (rx_stb_o)
  );
endmodule

// File: tb/fe_rx_decoder_bench.sv
module fe_rx_decoder_bench;
  localparam int ULIM = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sym = 2'b00;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, rx_stb, lock;

  always #10 clk = ~clk;

  fe_rx_decoder #(.UNLOCK_LIM(ULIM)) u_fe_rx_decoder (
    .clk(clk), .rst(rst), .sym_i(sym), .rxd_o(rxd), .rx_dv_o(rx_dv),
    .rx_er_o(rx_er), .rx_stb_o(rx_stb), .lock_o(lock)
  );

  int         n_chk = 0, n_fail = 0, n_got = 0;
  bit         done = 0;
  logic [10:0] slfsr;
  int         mlt = 0;
  logic [3:0] got_d [0:63];
  logic       got_e [0:63];

  always @(negedge clk)
    if (!rst && rx_stb && rx_dv && n_got < 64) begin
      got_d[n_got] = rxd;
      got_e[n_got] = rx_er;
      n_got = n_got + 1;
    end

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011; 4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [1:0] lvl(input int st);
    case (st)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_bit(input bit p);
    logic k;
    k = slfsr[10] ^ slfsr[8];
    slfsr = {slfsr[9:0], k};
    if (p ^ k) mlt = (mlt + 1) % 4;
    @(negedge clk);
    sym = lvl(mlt);
  endtask

  task automatic put_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) put_bit(g[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b1);
  endtask

  task automatic do_reset(input logic [10:0] seed);
    @(negedge clk);
    rst = 1'b1; sym = 2'b00; mlt = 0; slfsr = seed;
    repeat (3) @(negedge clk);
    chk(lock == 0, "R2 lock in reset", lock, 0);
    chk(rx_dv == 0 && rx_er == 0, "R4 R7 dv/er in reset", {rx_dv, rx_er}, 0);
    rst = 1'b0;
  endtask

  task automatic frame(input int n, input int mul, input int add, input int bad_at, input bit idle_end);
    n_got = 0;
    put_grp(5'b11000); put_grp(5'b10001);
    for (int k = 0; k < n; k++)
      if (k == bad_at) put_grp(5'b00000);
      else put_grp(enc(4'((k * mul + add) & 15)));
    if (!idle_end) begin put_grp(5'b01101); put_grp(5'b00111); end
    idle(40);
    chk(n_got == n, idle_end ? "R6 count, idle end" : "R4 R6 count", n_got, n);
    chk(rx_dv == 0, "R6 dv low after end", rx_dv, 0);
    for (int k = 0; k < n && k < n_got; k++) begin
      int e;
      e = (k == bad_at) ? 14 : ((k * mul + add) & 15);
      chk(got_d[k] == 4'(e), "R1 R3 R5 R7 nibble", got_d[k], e);
      chk(got_e[k] == (k == bad_at), "R7 error flag", got_e[k], (k == bad_at) ? 1 : 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [10:0] seeds [0:3];
    seeds[0] = 11'h001; seeds[1] = 11'h5A5; seeds[2] = 11'h7FF; seeds[3] = 11'h2C3;
    for (int s = 0; s < 4; s++) begin
      do_reset(seeds[s]);
      idle(20);
      chk(lock == 0, "R2 no lock before run", lock, 0);
      idle(60);
      chk(lock == 1, "R2 lock after idle", lock, 1);
      frame(16, 1, 0, -1, 0);
      frame(24, 7, s * 5, -1, 0);
      frame(9, 3, 5, 4, 0);
      frame(6, 5, 2, -1, 1);
      n_got = 0;
      put_grp(5'b11000);
      for (int i = 0; i < 4; i++) put_grp(5'b01011);
      idle(40);
      chk(n_got == 0, "R10 lone first half", n_got, 0);
      begin
        int c;
        c = 0;
        for (int i = 0; i < 50; i++) begin
          put_bit(1'b1);
          if (rx_stb) c++;
        end
        chk(c == 10, "R9 strobe rate", c, 10);
      end
    end
    repeat (300) @(negedge clk);
    chk(lock == 1, "R8 lock held under limit", lock, 1);
    repeat (150) @(negedge clk);
    chk(lock == 0, "R8 lock dropped", lock, 0);
    idle(100);
    chk(lock == 1, "R2 relock", lock, 1);
    frame(12, 11, 3, -1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule